// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for a parallel RGB panel: a pixel-rate enable, horizontal sync, vertical sync, a data-valid window and a frame interrupt. A fast source clock is divided down by a programmable ratio. Each enabled source cycle advances a pixel counter. Line ends advance a line counter. Within each axis, the regions follow one another in a fixed order: the active region first, then the front porch, then the sync pulse, then the back porch.

All timing values are loaded through a small parallel configuration port: a write strobe, a 3-bit address and a 32-bit data word. Every length field holds the length minus one. Timing runs only while the run bit is set. A self-clearing restart bit returns the raster to its first pixel. The frame interrupt is a pending flag that is set when vertical sync begins, if it is allowed to be. Software clears it by writing a one to it. The parameters `HS_INV` and `VS_INV` invert the sync outputs, and the idle level follows the inversion. Both syncs are active-high by default.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, `pix_en`, `de` and `frame_irq` are low and both syncs are at their inactive level; the run bit and all fields are zero.
- R2: While running with divider field value D (address 5, bits [7:0]), `pix_en` is high in exactly one of every D+1 source cycles; with D=0 it is high every cycle.
- R3: The divide ratio saturates at 255: a divider field of 255 gives the same pulse spacing (255 cycles) as a field of 254.
- R4: A line consists of HA+1 active, HF+1 front-porch, HS+1 sync and HB+1 back-porch pixels in that order. HA is at address 1, bits [11:0]. HF, HB and HS are at address 2, in bits [7:0], [15:8] and [23:16] respectively. `hsync` is active exactly during the sync pixels.
- R5: A frame consists of VA+1 active, VF+1 front-porch, VS+1 sync and VB+1 back-porch lines in that order. VA is at address 3. VF, VB and VS are at address 4, in the same bit layout as address 2. `vsync` is active for whole lines.
- R6: `de` is high exactly when both the pixel and the line lie in their active regions.
- R7: `frame_irq` becomes set at the first pixel of the first vertical sync line only when the global enable (address 6 bit 0) and the frame enable (bit 1) are set and the source select (bits [3:2]) equals 0, meaning vsync; with any other setting it stays low.
- R8: Writing address 7 with bit 0 set clears `frame_irq`; a write with bit 0 clear leaves it set; a new set event in the same cycle wins over the clear.
- R9: Clearing the run bit (address 0 bit 0) forces `pix_en` and `de` low and both syncs inactive, and zeroes the counters; setting it again restarts the raster at the first active pixel of the first line.
- R10: Writing address 0 with bit 1 set restarts the raster at the first pixel of line 0 on that write. The run bit is taken from bit 0 of the same write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| pix_en | output | 1 | Pixel-rate enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Active video window |
| frame_irq | output | 1 | Frame interrupt pending flag |

## Verification
The bench checks the degenerate timings in which every porch and sync field is zero. In those timings, regions last one pixel and an off-by-one in any boundary would shift `hsync` or `de` by a pixel or merge two regions. It measures the pulse spacing for divider fields 254 and 255. A divider without saturation would give a spacing of 256 instead of 255. The interrupt is driven through every combination of enables and every selector value. A wrong gate would raise `frame_irq` when no vsync source is chosen, or miss the vsync start. The bench also restarts the raster and stops it mid-frame. If the counters were not cleared, `de` would resume mid-line instead of at the first pixel.

// File: rtl/disp_timing_gen.sv
module disp_timing_gen #(
  parameter int CW     = 12,
  parameter int PW     = 8,
  parameter int DW     = 8,
  parameter bit HS_INV = 1'b0,
  parameter bit VS_INV = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        pix_en,
  output logic        hsync,
  output logic        vsync,
  output logic        de,
  output logic        frame_irq
);
  localparam int TW = CW + 2;
  localparam logic [DW-1:0] DIV_TOP = {DW{1'b1}} - DW'(1);

  logic [CW-1:0] ha, va;
  logic [PW-1:0] hf, hb, hs, vf, vb, vs;
  logic [DW-1:0] div_f, div_cnt;
  logic          run, gie, fie, pend;
  logic [1:0]    fsel;
  logic [TW-1:0] h_cnt, v_cnt;

  wire restart = cfg_we && cfg_addr == 3'd0 && cfg_wdata[1];
  wire clr_irq = cfg_we && cfg_addr == 3'd7 && cfg_wdata[0];

  wire [TW-1:0] h_sy = TW'(ha) + TW'(hf) + TW'(2);
  wire [TW-1:0] h_bp = h_sy + TW'(hs) + TW'(1);
  wire [TW-1:0] h_last = h_bp + TW'(hb);
  wire [TW-1:0] v_sy = TW'(va) + TW'(vf) + TW'(2);
  wire [TW-1:0] v_bp = v_sy + TW'(vs) + TW'(1);
  wire [TW-1:0] v_last = v_bp + TW'(vb);

  wire [DW-1:0] div_eff = (div_f == {DW{1'b1}}) ? DIV_TOP : div_f;

  assign pix_en = run && div_cnt == div_eff;
  wire line_end = pix_en && h_cnt == h_last;
  wire vs_begin = line_end && v_cnt == v_sy - TW'(1) && !restart;

  assign de     = run && h_cnt <= TW'(ha) && v_cnt <= TW'(va);
  assign hsync  = (run && h_cnt >= h_sy && h_cnt < h_bp) ^ HS_INV;
  assign vsync  = (run && v_cnt >= v_sy && v_cnt < v_bp) ^ VS_INV;
  assign frame_irq = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; gie <= 1'b0; fie <= 1'b0; fsel <= '0;
      ha <= '0; va <= '0; div_f <= '0;
      hf <= '0; hb <= '0; hs <= '0;
      vf <= '0; vb <= '0; vs <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: run <= cfg_wdata[0];
        3'd1: ha <= cfg_wdata[CW-1:0];
        3'd2: begin
          hf <= cfg_wdata[PW-1:0];
          hb <= cfg_wdata[PW+7:8];
          hs <= cfg_wdata[PW+15:16];
        end
        3'd3: va <= cfg_wdata[CW-1:0];
        3'd4: begin
          vf <= cfg_wdata[PW-1:0];
          vb <= cfg_wdata[PW+7:8];
          vs <= cfg_wdata[PW+15:16];
        end
        3'd5: div_f <= cfg_wdata[DW-1:0];
        3'd6: begin
          gie  <= cfg_wdata[0];
          fie  <= cfg_wdata[1];
          fsel <= cfg_wdata[3:2];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0; h_cnt <= '0; v_cnt <= '0;
    end else if (!run || restart) begin
      div_cnt <= '0; h_cnt <= '0; v_cnt <= '0;
    end else if (pix_en) begin
      div_cnt <= '0;
      if (line_end) begin
        h_cnt <= '0;
        v_cnt <= (v_cnt == v_last) ? '0 : v_cnt + TW'(1);
      end else begin
        h_cnt <= h_cnt + TW'(1);
      end
    end else begin
      div_cnt <= div_cnt + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    pend <= 1'b0;
    else if (vs_begin && gie && fie && fsel == 2'd0) pend <= 1'b1;
    else if (clr_irq)                              pend <= 1'b0;
  end
endmodule

module disp_timing_chk #(
  parameter bit HS_INV = 1'b0,
  parameter bit VS_INV = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       cfg_we,
  input logic [2:0] cfg_addr,
  input logic       cfg_bit0,
  input logic       pix_en,
  input logic       hsync,
  input logic       vsync,
  input logic       de,
  input logic       frame_irq
);
  // R6
  de_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync == HS_INV && vsync == VS_INV));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!pix_en && !de && hsync == HS_INV && vsync == VS_INV));
  // R7
  irq_on_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_irq) |-> (vsync != VS_INV || !run));
  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_irq && !(cfg_we && cfg_addr == 3'd7 && cfg_bit0)) |=> frame_irq);
endmodule

bind disp_timing_gen disp_timing_chk #(.HS_INV(HS_INV), .VS_INV(VS_INV)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_bit0(cfg_wdata[0]), .pix_en(pix_en), .hsync(hsync), .vsync(vsync),
  .de(de), .frame_irq(frame_irq)
);

// File: tb/sim_disp_timing_gen.sv
module sim_disp_timing_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic pix_en, hsync, vsync, de, frame_irq;
  int tests = 0, fails = 0, shown = 0;
  bit track = 1'b0;

  always #4 clk = ~clk;

  disp_timing_gen u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_en(pix_en), .hsync(hsync), .vsync(vsync), .de(de),
    .frame_irq(frame_irq));

  // reference raster built from the requirements
  int m_en, m_ha, m_va, m_hf, m_hb, m_hs, m_vf, m_vb, m_vs, m_div, m_gie, m_fie, m_sel;
  int m_dc, m_h, m_v, m_pend;

  function automatic int eff(int f); return (f == 255) ? 254 : f; endfunction
  function automatic bit e_pix(); return m_en != 0 && m_dc == eff(m_div); endfunction
  function automatic bit e_de(); return m_en != 0 && m_h <= m_ha && m_v <= m_va; endfunction
  function automatic bit e_hs();
    return m_en != 0 && m_h >= m_ha + m_hf + 2 && m_h < m_ha + m_hf + m_hs + 3;
  endfunction
  function automatic bit e_vs();
    return m_en != 0 && m_v >= m_va + m_vf + 2 && m_v < m_va + m_vf + m_vs + 3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ha = 0; m_va = 0; m_hf = 0; m_hb = 0; m_hs = 0; m_vf = 0; m_vb = 0;
      m_vs = 0; m_div = 0; m_gie = 0; m_fie = 0; m_sel = 0; m_dc = 0; m_h = 0; m_v = 0;
      m_pend = 0;
    end else begin
      automatic bit pe = e_pix();
      automatic bit rs = cfg_we && cfg_addr == 0 && cfg_wdata[1];
      automatic bit ev = 1'b0;
      automatic int htot = m_ha + m_hf + m_hs + m_hb + 4;
      automatic int vtot = m_va + m_vf + m_vs + m_vb + 4;
      if (m_en == 0 || rs) begin
        m_dc = 0; m_h = 0; m_v = 0;
      end else if (pe) begin
        m_dc = 0;
        if (m_h == htot - 1) begin
          m_h = 0;
          m_v = (m_v == vtot - 1) ? 0 : m_v + 1;
          ev = (m_v == m_va + m_vf + 2);
        end else m_h = m_h + 1;
      end else m_dc = m_dc + 1;
      if (ev && m_gie != 0 && m_fie != 0 && m_sel == 0) m_pend = 1;
      else if (cfg_we && cfg_addr == 7 && cfg_wdata[0]) m_pend = 0;
      if (cfg_we) case (cfg_addr)
        0: m_en = cfg_wdata[0];
        1: m_ha = int'(cfg_wdata[11:0]);
        2: begin m_hf = int'(cfg_wdata[7:0]); m_hb = int'(cfg_wdata[15:8]); m_hs = int'(cfg_wdata[23:16]); end
        3: m_va = int'(cfg_wdata[11:0]);
        4: begin m_vf = int'(cfg_wdata[7:0]); m_vb = int'(cfg_wdata[15:8]); m_vs = int'(cfg_wdata[23:16]); end
        5: m_div = int'(cfg_wdata[7:0]);
        6: begin m_gie = int'(cfg_wdata[0]); m_fie = int'(cfg_wdata[1]); m_sel = int'(cfg_wdata[3:2]); end
        default: ;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      if (shown < 20) $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      shown++;
    end
  endtask

  // continuous comparison against the reference raster, away from the clock edge
  always @(negedge clk) if (track) begin
    check(pix_en == e_pix(), "R2 pix_en", pix_en, e_pix());
    check(hsync == e_hs(), "R4 hsync", hsync, e_hs());
    check(vsync == e_vs(), "R5 vsync", vsync, e_vs());
    check(de == e_de(), "R6 de", de, e_de());
    check(frame_irq == m_pend[0], "R7 frame_irq", frame_irq, m_pend);
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 32'(d);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic setup(input int ha, input int va, input int hf, input int hb, input int hs,
                       input int vf, input int vb, input int vs, input int dv);
    wr(0, 0); wr(1, ha); wr(3, va);
    wr(2, (hs << 16) | (hb << 8) | hf); wr(4, (vs << 16) | (vb << 8) | vf);
    wr(5, dv); wr(0, 1);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!pix_en && !de && !frame_irq, "R1 outputs idle", {pix_en, de, frame_irq}, 0);
    check(!hsync && !vsync, "R1 syncs inactive", {hsync, vsync}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pix_en && !de && !hsync && !vsync, "R1 idle after release", {pix_en, de, hsync, vsync}, 0);
    track = 1'b1;

    // degenerate all-zero porches, R4/R5
    setup(0, 0, 0, 0, 0, 0, 0, 0, 0);
    wr(6, 3);
    repeat (60) @(negedge clk);

    // random timings with interrupt settings, R2 R4 R5 R6 R7 R8
    for (int i = 0; i < 12; i++) begin
      automatic int dv = $urandom_range(0, 3);
      setup($urandom_range(0, 7), $urandom_range(0, 5), $urandom_range(0, 2),
            $urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 2),
            $urandom_range(0, 2), $urandom_range(0, 2), dv);
      wr(6, $urandom_range(0, 15));
      for (int k = 0; k < 8; k++) begin
        repeat ($urandom_range(50, 200)) @(negedge clk);
        if ($urandom_range(0, 1) == 1) wr(7, $urandom_range(0, 1));
      end
    end

    // R3 saturation: fields 254 and 255 both give spacing 255
    for (int f = 254; f <= 255; f++) begin
      automatic int gap = 0;
      setup(3, 2, 0, 0, 0, 0, 0, 0, f);
      while (!pix_en) @(negedge clk);
      do begin @(negedge clk); gap++; end while (!pix_en);
      check(gap == 255, "R3 divider saturation spacing", gap, 255);
    end

    // R7 selector and enable gating
    setup(3, 2, 0, 0, 0, 0, 0, 0, 0);
    wr(7, 1);
    wr(6, 7);  repeat (100) @(negedge clk);
    check(!frame_irq, "R7 selector not vsync", frame_irq, 0);
    wr(6, 2);  repeat (100) @(negedge clk);
    check(!frame_irq, "R7 global enable off", frame_irq, 0);
    wr(6, 1);  repeat (100) @(negedge clk);
    check(!frame_irq, "R7 frame enable off", frame_irq, 0);
    wr(6, 3);  repeat (100) @(negedge clk);
    check(frame_irq, "R7 vsync source raises", frame_irq, 1);

    // R8 write-one-to-clear
    wr(6, 0);
    wr(7, 0);
    check(frame_irq, "R8 zero write keeps pending", frame_irq, 1);
    wr(7, 1);
    check(!frame_irq, "R8 one write clears", frame_irq, 0);

    // R9 stop and restart
    repeat (13) @(negedge clk);
    wr(0, 0);
    check(!de && !pix_en && !hsync && !vsync, "R9 stopped outputs", {de, pix_en, hsync, vsync}, 0);
    wr(0, 1);
    check(de && pix_en, "R9 restart at first active pixel", {de, pix_en}, 3);

    // R10 restart bit mid-frame
    repeat (17) @(negedge clk);
    wr(0, 3);
    check(de, "R10 restart bit returns to pixel 0", de, 1);
    repeat (50) @(negedge clk);

    track = 1'b0;
    finish_run();
  end
endmodule